// File: doc/BRIEF.md
# Local Interrupt In-Service Tracker

This block sits next to a processor core and takes in interrupt vectors from an upstream router. Each vector is an 8-bit number that arrives over a valid/ready handshake. The block holds a 256-bit request set and a 256-bit in-service set. It raises a single interrupt line to the core while it is globally enabled and some request is pending.

When the core acknowledges, the lowest pending vector moves from the request set to the in-service set. That vector is handed back on an acknowledge-data port. Software finishes an interrupt by writing anything to the end-of-interrupt register. This clears the in-service vector that the scan output currently names, and it emits a one-cycle pulse carrying that vector back to the router.

A small memory-mapped register file exposes three things:
- the global enable;
- the end-of-interrupt register;
- the in-service set, as eight 32-bit words on a 16-byte stride.

A scan output always gives one plus the lowest in-service vector, or zero when nothing is in service.

Top module: `lirq_tracker`

## Requirements
- R1: `vec_ready` is 1 at all times, and a vector offered with `vec_valid` high is taken on that same clock edge; its request bit is set from the following cycle.
- R2: Vector 255 is reserved and is never entered into the request set; offering it changes nothing.
- R3: Bit 8 of the register at byte offset 0x0F0 is the global enable. It is cleared by reset and written from `bus_wdata[8]`. A read returns the enable in bit 8 and zero in every other bit. While it is 0, `cpu_irq` is 0.
- R4: `cpu_irq` is 1 exactly when the enable is set and at least one request bit is set. It is a combinational function of the registered state.
- R5: A cycle with `cpu_ack` high and a non-empty request set clears the lowest set request bit and sets the same bit in the in-service set. From the next cycle, `ack_vector` holds that vector until the next acknowledge.
- R6: A cycle with `cpu_ack` high and an empty request set leaves both sets unchanged, and `ack_vector` becomes 255 from the next cycle.
- R7: A vector offered while its request bit is already set is absorbed: one acknowledge services it once, and a second acknowledge finds no request.
- R8: `lowest_isr` equals 1 + the index of the lowest set in-service bit, or 0 when the in-service set is empty.
- R9: The in-service set reads as word k (k = 0..7) at byte offset 0x100 + 16*k, where bit j of word k is vector 32*k + j. Any other address in that window (the 12 padding bytes after each word) reads 0.
- R10: A write of any value to byte offset 0x0B0 while the in-service set is non-empty clears the in-service bit named by `lowest_isr`. On the next cycle, `eoi_pulse` is high for exactly one cycle with `eoi_vector` equal to that vector. With an empty in-service set, such a write produces no pulse.
- R11: A read of byte offset 0x0B0 returns 0.
- R12: After reset, both sets are empty, the enable is 0, `cpu_irq` and `eoi_pulse` are 0, `ack_vector` is 0 and `lowest_isr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| vec_valid | input | 1 | Router offers a vector |
| vec_data | input | 8 | Offered vector number |
| vec_ready | output | 1 | Always 1: the block accepts every cycle |
| cpu_irq | output | 1 | Interrupt request to the core |
| cpu_ack | input | 1 | Core acknowledge, one cycle per interrupt taken |
| ack_vector | output | 8 | Vector moved to in-service by the last acknowledge, 255 if none |
| bus_addr | input | 12 | Register byte address |
| bus_wen | input | 1 | Register write strobe |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for `bus_addr` (combinational) |
| lowest_isr | output | 9 | 1 + lowest in-service vector, 0 if none |
| eoi_pulse | output | 1 | One-cycle end-of-interrupt notice |
| eoi_vector | output | 8 | Vector completed, valid with `eoi_pulse` |

## Verification
Vectors are injected out of numerical order (200, 40, 3) with a duplicate of 40 and the reserved 255 mixed in. The acknowledge sequence therefore shows whether selection follows lowest index rather than arrival order, and whether duplicates and the reserved vector are kept out of the request set. A vector injected before the enable is set tells gating apart from loss: it must stay silent, then raise `cpu_irq` as soon as the enable is written.

Repeated end-of-interrupt writes walk the in-service set upward through vectors 3, 40 and 200, then hit it when empty. This separates "clear the lowest" from "clear the most recent" and confirms that nothing is pulsed for an empty set. Vector 0 exercises the one-based scan at its lower edge. Reads at the word offsets and at a padding offset confirm the bit-to-vector mapping of the in-service words.

// File: rtl/lirq_pkg.sv
`timescale 1ns/1ps
package lirq_pkg;

  // Register map (byte offsets); software and the router depend on these.
  localparam int unsigned OFS_EOI    = 32'h0B0;
  localparam int unsigned OFS_SVR    = 32'h0F0;
  localparam int unsigned OFS_ISR    = 32'h100;
  localparam int unsigned ISR_STRIDE = 16;
  localparam int unsigned SVR_EN_BIT = 8;

  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_EOI,
    SEL_SVR,
    SEL_ISR
  } reg_sel_e;

endpackage

// File: rtl/lirq_pending.sv
`timescale 1ns/1ps
module lirq_pending #(
  parameter int unsigned NVEC = 256,
  localparam int unsigned VW = $clog2(NVEC)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [VW-1:0]   in_vec,
  input  logic            take,
  output logic [NVEC-1:0] req_q,
  output logic            take_hit,
  output logic [VW-1:0]   ack_vec_q
);

  function automatic logic [VW-1:0] lowest_idx(input logic [NVEC-1:0] v);
    logic [VW-1:0] r;
    r = '0;
    for (int i = NVEC - 1; i >= 0; i--) begin
      if (v[i]) r = VW'(i);
    end
    return r;
  endfunction

  logic            accept_ok;
  logic [VW-1:0]   take_idx;
  logic [NVEC-1:0] set_mask;
  logic [NVEC-1:0] clr_mask;

  assign accept_ok = in_valid && (in_vec != VW'(NVEC - 1));
  assign take_idx  = lowest_idx(req_q);
  assign take_hit  = take && (req_q != '0);
  assign set_mask  = accept_ok ? (NVEC'(1) << in_vec) : '0;
  assign clr_mask  = take_hit ? (NVEC'(1) << take_idx) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q     <= '0;
      ack_vec_q <= '0;
    end else begin
      req_q <= (req_q & ~clr_mask) | set_mask;
      if (take) ack_vec_q <= take_hit ? take_idx : '1;
    end
  end

endmodule

// File: rtl/lirq_service.sv
`timescale 1ns/1ps
module lirq_service #(
  parameter int unsigned NVEC = 256,
  localparam int unsigned VW = $clog2(NVEC)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            set_en,
  input  logic [VW-1:0]   set_vec,
  input  logic            eoi_wr,
  output logic [NVEC-1:0] isr_q,
  output logic [VW:0]     lowest1,
  output logic            eoi_fire,
  output logic            eoi_pulse_q,
  output logic [VW-1:0]   eoi_vec_q
);

  function automatic logic [VW-1:0] lowest_idx(input logic [NVEC-1:0] v);
    logic [VW-1:0] r;
    r = '0;
    for (int i = NVEC - 1; i >= 0; i--) begin
      if (v[i]) r = VW'(i);
    end
    return r;
  endfunction

  logic [VW-1:0]   low_idx;
  logic            any_isr;
  logic [NVEC-1:0] set_mask;
  logic [NVEC-1:0] clr_mask;

  assign low_idx  = lowest_idx(isr_q);
  assign any_isr  = (isr_q != '0);
  assign lowest1  = any_isr ? ({1'b0, low_idx} + (VW+1)'(1)) : '0;
  assign eoi_fire = eoi_wr && any_isr;
  assign set_mask = set_en ? (NVEC'(1) << set_vec) : '0;
  assign clr_mask = eoi_fire ? (NVEC'(1) << low_idx) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      isr_q       <= '0;
      eoi_pulse_q <= 1'b0;
      eoi_vec_q   <= '0;
    end else begin
      isr_q       <= (isr_q & ~clr_mask) | set_mask;
      eoi_pulse_q <= eoi_fire;
      if (eoi_fire) eoi_vec_q <= low_idx;
    end
  end

endmodule

// File: rtl/lirq_regs.sv
`timescale 1ns/1ps
module lirq_regs
  import lirq_pkg::*;
#(
  parameter int unsigned NVEC = 256,
  parameter int unsigned AW   = 12,
  parameter int unsigned DW   = 32,
  localparam int unsigned NWORDS    = NVEC / DW,
  localparam int unsigned WIX       = (NWORDS > 1) ? $clog2(NWORDS) : 1,
  localparam int unsigned STRIDE_LG = $clog2(ISR_STRIDE)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   bus_addr,
  input  logic            bus_wen,
  input  logic [DW-1:0]   bus_wdata,
  input  logic [NVEC-1:0] isr_q,
  output logic            en_q,
  output logic            eoi_wr,
  output logic [DW-1:0]   bus_rdata
);

  function automatic reg_sel_e decode(input logic [AW-1:0] a);
    logic [AW-1:0] off;
    off = a - AW'(OFS_ISR);
    if (a == AW'(OFS_EOI)) return SEL_EOI;
    if (a == AW'(OFS_SVR)) return SEL_SVR;
    if ((a >= AW'(OFS_ISR)) && (off < AW'(NWORDS * ISR_STRIDE)) &&
        (off[STRIDE_LG-1:0] == '0)) return SEL_ISR;
    return SEL_NONE;
  endfunction

  reg_sel_e      sel;
  logic [AW-1:0] isr_off;
  logic [WIX-1:0] widx;
  logic [DW-1:0] words [NWORDS];

  assign sel     = decode(bus_addr);
  assign isr_off = bus_addr - AW'(OFS_ISR);
  assign widx    = isr_off[STRIDE_LG +: WIX];
  assign eoi_wr  = bus_wen && (sel == SEL_EOI);

  for (genvar k = 0; k < NWORDS; k++) begin : g_word
    assign words[k] = isr_q[k*DW +: DW];
  end

  wire unused_wdata = ^{bus_wdata[DW-1:SVR_EN_BIT+1], bus_wdata[SVR_EN_BIT-1:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= 1'b0;
    else if (bus_wen && (sel == SEL_SVR)) en_q <= bus_wdata[SVR_EN_BIT];
  end

  always_comb begin
    unique case (sel)
      SEL_SVR: bus_rdata = DW'(en_q) << SVR_EN_BIT;
      SEL_ISR: bus_rdata = words[widx];
      default: bus_rdata = '0;
    endcase
  end

endmodule

// File: rtl/lirq_tracker.sv
`timescale 1ns/1ps
module lirq_tracker #(
  parameter int unsigned NVEC = 256,
  parameter int unsigned AW   = 12,
  parameter int unsigned DW   = 32,
  localparam int unsigned VW  = $clog2(NVEC)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          vec_valid,
  input  logic [VW-1:0] vec_data,
  output logic          vec_ready,
  output logic          cpu_irq,
  input  logic          cpu_ack,
  output logic [VW-1:0] ack_vector,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_wen,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic [VW:0]   lowest_isr,
  output logic          eoi_pulse,
  output logic [VW-1:0] eoi_vector
);

  // Internal events, named for the bound checker.
  logic [NVEC-1:0] req_q;
  logic [NVEC-1:0] isr_q;
  logic            take_hit;
  logic            en_q;
  logic            eoi_wr;
  logic            eoi_fire;

  assign vec_ready = 1'b1;
  assign cpu_irq   = en_q && (req_q != '0);

  lirq_pending #(.NVEC(NVEC)) u_pending (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (vec_valid),
    .in_vec    (vec_data),
    .take      (cpu_ack),
    .req_q     (req_q),
    .take_hit  (take_hit),
    .ack_vec_q (ack_vector)
  );

  lirq_service #(.NVEC(NVEC)) u_service (
    .clk         (clk),
    .rst_n       (rst_n),
    .set_en      (take_hit),
    .set_vec     (ack_vector_next()),
    .eoi_wr      (eoi_wr),
    .isr_q       (isr_q),
    .lowest1     (lowest_isr),
    .eoi_fire    (eoi_fire),
    .eoi_pulse_q (eoi_pulse),
    .eoi_vec_q   (eoi_vector)
  );

  lirq_regs #(.NVEC(NVEC), .AW(AW), .DW(DW)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wen   (bus_wen),
    .bus_wdata (bus_wdata),
    .isr_q     (isr_q),
    .en_q      (en_q),
    .eoi_wr    (eoi_wr),
    .bus_rdata (bus_rdata)
  );

  // Lowest pending request: the vector an acknowledge moves this cycle.
  function automatic logic [VW-1:0] ack_vector_next();
    logic [VW-1:0] r;
    r = '0;
    for (int i = NVEC - 1; i >= 0; i--) begin
      if (req_q[i]) r = VW'(i);
    end
    return r;
  endfunction

endmodule

// File: rtl/lirq_tracker_chk.sv
`timescale 1ns/1ps
module lirq_tracker_chk #(
  parameter int unsigned NVEC = 256,
  parameter int unsigned AW   = 12,
  localparam int unsigned VW  = $clog2(NVEC)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            vec_ready,
  input logic            cpu_irq,
  input logic            cpu_ack,
  input logic [VW-1:0]   ack_vector,
  input logic [AW-1:0]   bus_addr,
  input logic            bus_wen,
  input logic [VW:0]     lowest_isr,
  input logic            eoi_pulse,
  input logic [VW-1:0]   eoi_vector,
  input logic            en_q,
  input logic [NVEC-1:0] req_q,
  input logic [NVEC-1:0] isr_q,
  input logic            take_hit
);

  // R1
  ready_high_chk: assert property (@(posedge clk) disable iff (!rst_n) vec_ready);

  // R2
  no_rsvd_req_chk: assert property (@(posedge clk) disable iff (!rst_n) !req_q[NVEC-1]);

  // R3
  irq_gated_chk: assert property (@(posedge clk) disable iff (!rst_n) !en_q |-> !cpu_irq);

  // R5
  ack_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ack && take_hit) |=> isr_q[ack_vector]);

  // R6
  spurious_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ack && (req_q == '0)) |=> (ack_vector == VW'(NVEC - 1)));

  // R8
  scan_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lowest_isr == '0) == (isr_q == '0));

  // R10
  eoi_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_pulse |-> $past(bus_wen && (bus_addr == AW'(lirq_pkg::OFS_EOI)) && (lowest_isr != '0)));

  // R10
  eoi_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_pulse |-> ({1'b0, eoi_vector} == $past(lowest_isr) - (VW+1)'(1)));

endmodule

bind lirq_tracker lirq_tracker_chk #(.NVEC(NVEC), .AW(AW)) u_chk (.*);

// File: tb/lirq_tracker_tb.sv
`timescale 1ns/1ps
module lirq_tracker_tb;
  localparam int NVEC = 256;
  localparam int AW = 12;
  localparam int DW = 32;
  localparam int VW = 8;
  localparam logic [AW-1:0] A_EOI = 12'h0B0;
  localparam logic [AW-1:0] A_SVR = 12'h0F0;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vec_valid = 1'b0;
  logic [VW-1:0] vec_data = '0;
  logic vec_ready, cpu_irq;
  logic cpu_ack = 1'b0;
  logic [VW-1:0] ack_vector;
  logic [AW-1:0] bus_addr = '0;
  logic bus_wen = 1'b0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic [VW:0] lowest_isr;
  logic eoi_pulse;
  logic [VW-1:0] eoi_vector;

  int n_tests = 0;
  int n_fail = 0;
  bit done = 1'b0;
  logic [VW-1:0] ack_exp_q[$];
  logic [VW-1:0] eoi_exp_q[$];
  logic ack_d = 1'b0;

  always #2.5 clk = ~clk;

  lirq_tracker u_dut (.*);

  task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(logic [VW-1:0] v);
    @(negedge clk); vec_valid = 1'b1; vec_data = v;
    @(negedge clk); vec_valid = 1'b0;
  endtask

  task automatic ack(logic [VW-1:0] exp);
    ack_exp_q.push_back(exp);
    @(negedge clk); cpu_ack = 1'b1;
    @(negedge clk); cpu_ack = 1'b0;
  endtask

  task automatic wr(logic [AW-1:0] a, logic [DW-1:0] d);
    @(negedge clk); bus_addr = a; bus_wen = 1'b1; bus_wdata = d;
    @(negedge clk); bus_wen = 1'b0;
  endtask

  task automatic eoi(bit expect_pulse, logic [VW-1:0] v);
    if (expect_pulse) eoi_exp_q.push_back(v);
    wr(A_EOI, 32'hDEAD_BEEF);
  endtask

  task automatic rd(string req, logic [AW-1:0] a, logic [DW-1:0] exp);
    @(negedge clk); bus_addr = a;
    #1 check(req, bus_rdata, exp);
  endtask

  // Monitor: compares produced results against the scoreboard queues.
  always @(posedge clk) ack_d <= cpu_ack;

  always @(negedge clk) begin
    if (rst_n && ack_d) begin
      n_tests++;
      if (ack_exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL R5 ack_vector actual=%0d expected=none", ack_vector);
      end else begin
        logic [VW-1:0] e;
        e = ack_exp_q.pop_front();
        if (ack_vector !== e) begin
          n_fail++;
          $display("FAIL R5/R6 ack_vector actual=%0d expected=%0d", ack_vector, e);
        end
      end
    end
    if (rst_n && eoi_pulse) begin
      n_tests++;
      if (eoi_exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL R10 eoi_pulse actual=1 expected=0 (vector %0d)", eoi_vector);
      end else begin
        logic [VW-1:0] e;
        e = eoi_exp_q.pop_front();
        if (eoi_vector !== e) begin
          n_fail++;
          $display("FAIL R10 eoi_vector actual=%0d expected=%0d", eoi_vector, e);
        end
      end
    end
  end

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    check("R12 cpu_irq", 32'(cpu_irq), 0);
    check("R12 lowest_isr", 32'(lowest_isr), 0);
    check("R12 ack_vector", 32'(ack_vector), 0);
    check("R12 eoi_pulse", 32'(eoi_pulse), 0);
    rd("R12 enable reg", A_SVR, 0);
    rd("R12 isr word0", 12'h100, 0);
    check("R1 vec_ready", 32'(vec_ready), 1);

    // R3: a request while disabled stays silent, then shows on enable
    send(8'd40);
    check("R3 irq while disabled", 32'(cpu_irq), 0);
    wr(A_SVR, 32'h0000_0100);
    check("R4 irq after enable", 32'(cpu_irq), 1);
    wr(A_SVR, 32'hFFFF_FFFF);
    rd("R3 enable readback", A_SVR, 32'h0000_0100);

    // R1 R2 R7: out-of-order, duplicate, reserved
    send(8'd200);
    send(8'd40);
    send(8'd3);
    send(8'd255);
    ack(8'd3);
    ack(8'd40);
    ack(8'd200);
    check("R2/R4 irq after drain", 32'(cpu_irq), 0);
    ack(8'd255);
    check("R8 lowest_isr", 32'(lowest_isr), 4);

    // R9 R11 register reads
    rd("R9 isr word0", 12'h100, 32'h0000_0008);
    rd("R9 isr word1", 12'h110, 32'h0000_0100);
    rd("R9 isr word6", 12'h160, 32'h0000_0100);
    rd("R9 padding", 12'h114, 0);
    rd("R11 eoi read", A_EOI, 0);

    // R10 completion walks upward
    eoi(1'b1, 8'd3);
    check("R10 lowest after eoi", 32'(lowest_isr), 41);
    eoi(1'b1, 8'd40);
    check("R10 lowest after eoi", 32'(lowest_isr), 201);
    eoi(1'b1, 8'd200);
    check("R8 lowest empty", 32'(lowest_isr), 0);
    eoi(1'b0, 8'd0);
    @(negedge clk);
    check("R10 no pulse when empty", 32'(eoi_pulse), 0);

    // R7 duplicate absorbed
    send(8'd77);
    send(8'd77);
    ack(8'd77);
    ack(8'd255);
    eoi(1'b1, 8'd77);

    // R8 vector 0 edge
    send(8'd0);
    ack(8'd0);
    check("R8 lowest for vector 0", 32'(lowest_isr), 1);
    eoi(1'b1, 8'd0);

    repeat (3) @(negedge clk);
    check("R5 ack queue drained", 32'(ack_exp_q.size()), 0);
    check("R10 eoi queue drained", 32'(eoi_exp_q.size()), 0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule